// File: doc/BRIEF.md
# Duplicate TLB entry scrubber

This block cleans up a set-associative translation buffer that holds two entries for the same virtual page. Such a duplicate shows up when a lookup hits more than one way. A single start pulse, typically raised by the overlap fault, makes the engine walk the buffer one set at a time. It reads every way of the set into a local copy and compares the page-number fields. For each entry that has a later way with the same page, it clears the entry through the buffer's write port.

The buffer storage is not part of the block. The engine drives a read strobe and a linear index, and it gets the first descriptor word of the entry back one cycle later. It drives an erase strobe with the same index, and the storage sets both descriptor words of that entry to zero. When the walk ends, the block raises a one-cycle done pulse. It holds the number of entries it erased and the set and way of the last one. When verbose reporting is on, each erase also produces a report pulse that carries the location and the descriptor that was removed.

Top module: `tlb_dup_scrub`

## Requirements
- R1: After reset, busy_o, done_o, tlb_rd_o, tlb_wr_o and rpt_valid_o are low, and erase_cnt_o, last_set_o and last_way_o are zero.
- R2: A start pulse in idle begins a walk. The walk visits sets in ascending order and reads every way of each set at linear index set*WAYS+way, also in ascending order. A walk therefore issues exactly SETS*WAYS reads.
- R3: A set in which no read descriptor has bit VALID_BIT set is left untouched, even when its entries carry equal pages.
- R4: Two entries match when the page field, bits PD_W-1 down to PAGE_LSB of the first descriptor word, is equal. The lower bits play no part in the match.
- R5: Way i is erased only if its descriptor is nonzero and some way j>i of the same set matches it. Each way is erased at most once per walk, the highest way is never erased, and the matching higher way is kept.
- R6: An erase is one tlb_wr_o cycle at the entry's linear index. It adds one to erase_cnt_o and loads last_set_o and last_way_o with the location of that entry.
- R7: While verbose_i is high, each erase drives rpt_valid_o for that cycle, with rpt_set_o, rpt_way_o and rpt_pd0_o set to the erased entry's location and descriptor. While verbose_i is low, rpt_valid_o stays low.
- R8: After the last set, done_o is high for exactly one cycle and busy_o then falls. A start pulse while busy_o is high, including the done cycle, is ignored.
- R9: A start accepted in idle clears erase_cnt_o, last_set_o and last_way_o, so a walk that finds no duplicates ends with all three at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse |
| verbose_i | input | 1 | Enables report pulses |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle end-of-walk pulse |
| tlb_rd_o | output | 1 | Read strobe, data returned next cycle |
| tlb_wr_o | output | 1 | Erase strobe, clears the entry at tlb_idx_o |
| tlb_idx_o | output | IDX_W | Linear entry index |
| tlb_pd0_i | input | PD_W | First descriptor word of the read entry |
| erase_cnt_o | output | CNT_W | Entries erased in this walk |
| last_set_o | output | SET_W | Set of the last erased entry |
| last_way_o | output | WAY_W | Way of the last erased entry |
| rpt_valid_o | output | 1 | Duplicate report strobe |
| rpt_set_o | output | SET_W | Reported set |
| rpt_way_o | output | WAY_W | Reported way |
| rpt_pd0_o | output | PD_W | Descriptor of the erased entry |

## Verification
Two events can fall in the same cycle and are checked directly: a start pulse can arrive while the engine is still working, and a start pulse can arrive exactly in the done cycle. To provoke the first, the bench raises start_i several cycles into every walk. It then checks that the read index sequence keeps its strict ascending order and that done_o appears exactly once. To provoke the second, the bench drives start_i in the cycle in which it sees done_o high and requires busy_o to be low afterwards. Erase and report pulses fall in the same cycle by design. The bench therefore compares the captured report list entry by entry with the erase list that its own model predicts.

// File: rtl/tlb_dup_scrub.sv
module tlb_dup_scrub #(
  parameter int SETS      = 8,
  parameter int WAYS      = 4,
  parameter int PD_W      = 32,
  parameter int PAGE_LSB  = 13,
  parameter int VALID_BIT = 8,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int IDX_W = $clog2(SETS * WAYS),
  localparam int CNT_W = $clog2(SETS * WAYS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             verbose_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             tlb_rd_o,
  output logic             tlb_wr_o,
  output logic [IDX_W-1:0] tlb_idx_o,
  input  logic [PD_W-1:0]  tlb_pd0_i,
  output logic [CNT_W-1:0] erase_cnt_o,
  output logic [SET_W-1:0] last_set_o,
  output logic [WAY_W-1:0] last_way_o,
  output logic             rpt_valid_o,
  output logic [SET_W-1:0] rpt_set_o,
  output logic [WAY_W-1:0] rpt_way_o,
  output logic [PD_W-1:0]  rpt_pd0_o
);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_CAP, S_SCAN, S_DONE} state_t;

  state_t           state_q;
  logic [SET_W-1:0] set_q;
  logic [WAY_W-1:0] way_q;
  logic             any_valid_q;
  logic [PD_W-1:0]  copy_q [WAYS];
  logic             hit;
  logic             last_way;
  logic             last_set;

  assign last_way = (way_q == WAY_W'(WAYS - 1));
  assign last_set = (set_q == SET_W'(SETS - 1));

  always_comb begin
    hit = 1'b0;
    for (int j = 1; j < WAYS; j++)
      if (WAY_W'(j) > way_q &&
          copy_q[j][PD_W-1:PAGE_LSB] == copy_q[way_q][PD_W-1:PAGE_LSB])
        hit = 1'b1;
    if (copy_q[way_q] == '0) hit = 1'b0;
  end

  assign busy_o      = (state_q != S_IDLE);
  assign done_o      = (state_q == S_DONE);
  assign tlb_rd_o    = (state_q == S_RD);
  assign tlb_wr_o    = (state_q == S_SCAN) && hit;
  assign tlb_idx_o   = IDX_W'(set_q) * IDX_W'(WAYS) + IDX_W'(way_q);
  assign rpt_valid_o = tlb_wr_o && verbose_i;
  assign rpt_set_o   = set_q;
  assign rpt_way_o   = way_q;
  assign rpt_pd0_o   = copy_q[way_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      set_q       <= '0;
      way_q       <= '0;
      any_valid_q <= 1'b0;
      erase_cnt_o <= '0;
      last_set_o  <= '0;
      last_way_o  <= '0;
      for (int w = 0; w < WAYS; w++) copy_q[w] <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (start_i) begin
          state_q     <= S_RD;
          set_q       <= '0;
          way_q       <= '0;
          any_valid_q <= 1'b0;
          erase_cnt_o <= '0;
          last_set_o  <= '0;
          last_way_o  <= '0;
        end
        S_RD: state_q <= S_CAP;
        S_CAP: begin
          copy_q[way_q] <= tlb_pd0_i;
          if (!last_way) begin
            any_valid_q <= any_valid_q | tlb_pd0_i[VALID_BIT];
            way_q       <= way_q + 1'b1;
            state_q     <= S_RD;
          end else if (any_valid_q | tlb_pd0_i[VALID_BIT]) begin
            way_q   <= '0;
            state_q <= S_SCAN;
          end else begin
            way_q       <= '0;
            any_valid_q <= 1'b0;
            set_q       <= last_set ? set_q : set_q + 1'b1;
            state_q     <= last_set ? S_DONE : S_RD;
          end
        end
        S_SCAN: begin
          if (hit) begin
            copy_q[way_q] <= '0;
            erase_cnt_o   <= erase_cnt_o + 1'b1;
            last_set_o    <= set_q;
            last_way_o    <= way_q;
          end
          if (!last_way) begin
            way_q <= way_q + 1'b1;
          end else begin
            way_q       <= '0;
            any_valid_q <= 1'b0;
            set_q       <= last_set ? set_q : set_q + 1'b1;
            state_q     <= last_set ? S_DONE : S_RD;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

endmodule

module tlb_dup_scrub_chk #(
  parameter int SETS  = 8,
  parameter int WAYS  = 4,
  parameter int PD_W  = 32,
  parameter int IDX_W = 5,
  parameter int CNT_W = 6,
  parameter int WAY_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             tlb_rd_o,
  input logic             tlb_wr_o,
  input logic [IDX_W-1:0] tlb_idx_o,
  input logic [CNT_W-1:0] erase_cnt_o,
  input logic [WAY_W-1:0] last_way_o,
  input logic             rpt_valid_o,
  input logic [PD_W-1:0]  rpt_pd0_o
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!tlb_rd_o && !tlb_wr_o && !rpt_valid_o));

  assert_idx_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tlb_rd_o || tlb_wr_o) |-> (int'(tlb_idx_o) < SETS * WAYS));

  assert_top_way_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_wr_o |-> ((int'(tlb_idx_o) % WAYS) != WAYS - 1));

  assert_last_way_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_cnt_o != '0) |-> (int'(last_way_o) < WAYS - 1));

  assert_rd_wr_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(tlb_rd_o && tlb_wr_o));

  assert_erase_counts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_wr_o |=> (erase_cnt_o == $past(erase_cnt_o) + 1'b1));

  assert_report_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_valid_o |-> (rpt_pd0_o != '0));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));

  assert_busy_from_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

endmodule

bind tlb_dup_scrub tlb_dup_scrub_chk #(
  .SETS(SETS), .WAYS(WAYS), .PD_W(PD_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .WAY_W(WAY_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
  .tlb_rd_o(tlb_rd_o), .tlb_wr_o(tlb_wr_o), .tlb_idx_o(tlb_idx_o),
  .erase_cnt_o(erase_cnt_o), .last_way_o(last_way_o),
  .rpt_valid_o(rpt_valid_o), .rpt_pd0_o(rpt_pd0_o)
);

// File: tb/tlb_dup_scrub_tb.sv
module tlb_dup_scrub_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SETS = 8;
  localparam int WAYS = 4;
  localparam int PD_W = 32;
  localparam int PAGE_LSB = 13;
  localparam int VB = 8;
  localparam int N = SETS * WAYS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic verbose_i = 1'b0;
  logic busy_o, done_o, tlb_rd_o, tlb_wr_o, rpt_valid_o;
  logic [4:0] tlb_idx_o;
  logic [PD_W-1:0] tlb_pd0_i, rpt_pd0_o;
  logic [5:0] erase_cnt_o;
  logic [2:0] last_set_o, rpt_set_o;
  logic [1:0] last_way_o, rpt_way_o;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  logic [PD_W-1:0] mem [N];
  logic [PD_W-1:0] exp_mem [N];
  int exp_idx [N];
  logic [PD_W-1:0] exp_pd [N];
  int exp_n;
  int got_idx [N];
  int got_n;
  int rpt_idx [N];
  logic [PD_W-1:0] rpt_pd [N];
  int rpt_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_dup_scrub #(.SETS(SETS), .WAYS(WAYS), .PD_W(PD_W), .PAGE_LSB(PAGE_LSB), .VALID_BIT(VB)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .verbose_i(verbose_i),
    .busy_o(busy_o), .done_o(done_o), .tlb_rd_o(tlb_rd_o), .tlb_wr_o(tlb_wr_o),
    .tlb_idx_o(tlb_idx_o), .tlb_pd0_i(tlb_pd0_i), .erase_cnt_o(erase_cnt_o),
    .last_set_o(last_set_o), .last_way_o(last_way_o), .rpt_valid_o(rpt_valid_o),
    .rpt_set_o(rpt_set_o), .rpt_way_o(rpt_way_o), .rpt_pd0_o(rpt_pd0_o));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (tlb_rd_o) tlb_pd0_i <= mem[tlb_idx_o];
    if (tlb_wr_o) mem[tlb_idx_o] <= '0;
  end

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [PD_W-PAGE_LSB-1:0] pg(logic [PD_W-1:0] x);
    return x[PD_W-1:PAGE_LSB];
  endfunction

  task automatic model();
    logic [PD_W-1:0] c [WAYS];
    bit any;
    bit hit;
    exp_n = 0;
    for (int i = 0; i < N; i++) exp_mem[i] = mem[i];
    for (int s = 0; s < SETS; s++) begin
      any = 0;
      for (int w = 0; w < WAYS; w++) begin
        c[w] = mem[s*WAYS+w];
        any |= c[w][VB];
      end
      if (!any) continue;
      for (int i = 0; i < WAYS - 1; i++) begin
        if (c[i] == '0) continue;
        hit = 0;
        for (int j = i + 1; j < WAYS; j++) if (pg(c[j]) == pg(c[i])) hit = 1;
        if (hit) begin
          exp_idx[exp_n] = s*WAYS+i;
          exp_pd[exp_n] = c[i];
          exp_n++;
          c[i] = '0;
          exp_mem[s*WAYS+i] = '0;
        end
      end
    end
  endtask

  function automatic logic [PD_W-1:0] mk(int page, bit valid);
    logic [PAGE_LSB-1:0] lo;
    lo = PAGE_LSB'($urandom);
    lo[VB] = valid;
    if (lo == '0) lo[0] = 1'b1;
    return {(PD_W-PAGE_LSB)'(page), lo};
  endfunction

  task automatic run(bit verb, string tag);
    int n;
    int rd_exp;
    int dones;
    bit seq_ok;
    bit mem_ok;
    bit rpt_ok;
    bit wr_ok;
    model();
    verbose_i = verb;
    got_n = 0; rpt_n = 0; rd_exp = 0; dones = 0; seq_ok = 1; n = 0;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    while (1) begin
      if (tlb_rd_o) begin
        if (int'(tlb_idx_o) != rd_exp) seq_ok = 0;
        rd_exp++;
      end
      if (tlb_wr_o && got_n < N) begin got_idx[got_n] = int'(tlb_idx_o); got_n++; end
      if (rpt_valid_o && rpt_n < N) begin
        rpt_idx[rpt_n] = int'(rpt_set_o) * WAYS + int'(rpt_way_o);
        rpt_pd[rpt_n] = rpt_pd0_o;
        rpt_n++;
      end
      if (done_o) dones++;
      n++;
      if (done_o || n > 4000) break;
      start_i = (n == 7 || n == 40);
      @(negedge clk);
    end
    start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    if (done_o) dones++;
    check("R8", {tag, " done pulse count"}, dones, 1);
    check("R8", {tag, " busy low after start in done cycle"}, busy_o, 0);
    check("R2", {tag, " read order ascending"}, seq_ok, 1);
    check("R2", {tag, " read count"}, rd_exp, N);
    wr_ok = (got_n == exp_n);
    for (int k = 0; k < exp_n && wr_ok; k++) if (got_idx[k] != exp_idx[k]) wr_ok = 0;
    check("R5", {tag, " erase index list matches"}, wr_ok, 1);
    mem_ok = 1;
    for (int i = 0; i < N; i++) if (mem[i] != exp_mem[i]) mem_ok = 0;
    check("R3", {tag, " buffer contents after walk"}, mem_ok, 1);
    check("R6", {tag, " erase count"}, erase_cnt_o, exp_n);
    check("R9", {tag, " last set"}, last_set_o, exp_n ? exp_idx[exp_n-1] / WAYS : 0);
    check("R9", {tag, " last way"}, last_way_o, exp_n ? exp_idx[exp_n-1] % WAYS : 0);
    rpt_ok = verb ? (rpt_n == exp_n) : (rpt_n == 0);
    for (int k = 0; k < rpt_n && rpt_ok && verb; k++)
      if (rpt_idx[k] != exp_idx[k] || rpt_pd[k] != exp_pd[k]) rpt_ok = 0;
    check("R7", {tag, " report list"}, rpt_ok, 1);
  endtask

  initial begin
    for (int i = 0; i < N; i++) mem[i] = '0;
    tlb_pd0_i = '0;
    repeat (3) @(negedge clk);
    check("R1", "busy after reset", busy_o, 0);
    check("R1", "done after reset", done_o, 0);
    check("R1", "strobes after reset", {tlb_rd_o, tlb_wr_o, rpt_valid_o}, 0);
    check("R1", "count after reset", erase_cnt_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "idle without start", busy_o, 0);

    run(1'b1, "empty");

    // R4 R5: set 0 one page in all ways, low bits differ -> ways 0..2 erased
    for (int w = 0; w < WAYS; w++) mem[w] = mk(5, 1'b1);
    // R3: set 1 duplicates but no valid bit -> untouched
    for (int w = 0; w < WAYS; w++) mem[WAYS+w] = mk(9, 1'b0);
    // R5: set 2 zero way 0, ways 1 and 2 share page
    mem[2*WAYS+0] = '0; mem[2*WAYS+1] = mk(3, 1'b1);
    mem[2*WAYS+2] = mk(3, 1'b0); mem[2*WAYS+3] = mk(4, 1'b1);
    run(1'b1, "directed");
    check("R4", "top way of set 0 kept", mem[WAYS-1] != '0, 1);
    check("R3", "invalid set kept", mem[WAYS] != '0, 1);

    run(1'b0, "rerun-clean");

    void'($urandom(32'd2024));
    for (int r = 0; r < 10; r++) begin
      for (int s = 0; s < SETS; s++) begin
        bit inval;
        inval = ($urandom_range(0, 4) == 0);
        for (int w = 0; w < WAYS; w++) begin
          if ($urandom_range(0, 6) == 0) mem[s*WAYS+w] = '0;
          else mem[s*WAYS+w] = mk($urandom_range(0, 3), inval ? 1'b0 : 1'($urandom_range(0, 3) != 0));
        end
      end
      run(1'($urandom_range(0, 1)), "random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule